// File: doc/BRIEF.md
# Serial Signed-Digit Coefficient Adder

This block adds a fixed template coefficient to a pixel value that streams in one radix-2 signed digit per clock, most significant digit first, and streams the sum out in the same signed-digit form. It is the additive local stage of a neighbourhood operator: the pixel stream passes through, and each word picks up the same constant.

The coefficient lives in two's complement in a small bit-addressed memory. The address does not come from a binary counter but from a maximal-length LFSR whose period equals the word length N = 2^LFSR_W - 1. Software therefore writes coefficient bit k (k counted from the MSB) at the k-th state the LFSR visits after its seed. The addition is carry-free: each sum digit depends only on a window of three input positions. The first sum digit leaves the block three cycles after the first input digit.

Top module: `sd_coef_adder`

## Requirements
- R1: A digit is a (plus, minus) pair on bits [1:0]. 2'b10 is +1, 2'b01 is -1 and 2'b00 is 0. The input never carries 2'b11, and sd_o never shows 2'b11.
- R2: A word is N = 2^LFSR_W - 1 digits on consecutive cycles (N = 7 by default). start_i is high with the first, most significant digit. Input outside a word is ignored, and the next start_i comes at least N+1 cycles after the previous one.
- R3: When coef_we_i is high, coef_bit_i is written to memory address coef_addr_i. The coefficient digit used at MSB-first index k is read from address s_k. Here s_0 = 1 (the seed, reloaded by every start_i) and s_(k+1) is s_k shifted left by one with bit 0 = XOR of the taps. For LFSR_W = 3 the taps are bits 2 and 1: 1, 2, 5, 3, 7, 6, 4.
- R4: The coefficient is an N-bit two's complement value. Its MSB (index 0) counts as a digit of weight -2^(N-1), and every other bit counts as a 0 or +1 digit of its binary weight.
- R5: Each word yields N+1 output digits, MSB first, on consecutive valid cycles. Their signed-digit value equals the input value plus the coefficient, for every coefficient and every input digit string, including redundant ones.
- R6: The first output digit of a word is valid exactly 3 cycles after the cycle in which start_i was high.
- R7: When sd_valid_o is low, sd_o is 2'b00. sd_valid_o is high only for the first digit of a word (3 cycles after start_i) or in the cycle right after another valid digit.
- R8: During and right after reset, sd_valid_o is low and sd_o is 2'b00, and the LFSR state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | High with the first digit of a word |
| sd_i | input | 2 | Input signed digit (plus, minus) |
| coef_we_i | input | 1 | Coefficient memory write enable |
| coef_addr_i | input | LFSR_W | Coefficient memory bit address |
| coef_bit_i | input | 1 | Coefficient bit to write |
| sd_o | output | 2 | Output signed digit (plus, minus) |
| sd_valid_o | output | 1 | Output digit is part of a sum word |

## Verification
On every cycle the assertions check the output digit code, the quiet output between words, the fixed three-cycle latency after each start, the fact that every valid digit is either a word head or continues a run, and an LFSR that never sits in the all-zero state. Only the bench scenarios show that the digit strings really add up to input plus coefficient. For that it loads all 128 coefficients in LFSR order and feeds the extreme, zero, alternating and random redundant inputs with varied gaps between words.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

  typedef logic signed [2:0] sval_t;

  typedef struct packed {
    sval_t t;  // transfer into next higher position
    sval_t w;  // interim digit kept at this position
  } xfer_t;

  // feedback taps for shift-left Fibonacci LFSRs, two-tap maximal polynomials
  function automatic logic [7:0] tap_mask(int unsigned w);
    case (w)
      3: return 8'b0000_0110;
      4: return 8'b0000_1100;
      5: return 8'b0001_0100;
      6: return 8'b0011_0000;
      7: return 8'b0110_0000;
      default: return 8'b0000_0000;
    endcase
  endfunction

  function automatic sval_t dig_val(logic [1:0] d);
    case (d)
      2'b10: return sval_t'(1);
      2'b01: return sval_t'(-1);
      default: return sval_t'(0);
    endcase
  endfunction

  function automatic logic [1:0] dig_enc(sval_t v);
    if (v == sval_t'(1)) return 2'b10;
    if (v == sval_t'(-1)) return 2'b01;
    return 2'b00;
  endfunction

  // split a position sum in [-2,2] so that the interim digit absorbs any transfer
  function automatic xfer_t split(sval_t hi, sval_t lo);
    xfer_t r;
    logic  lo_neg;
    lo_neg = lo[2];
    r.t = sval_t'(0);
    r.w = sval_t'(0);
    case (hi)
      sval_t'(2):  r.t = sval_t'(1);
      sval_t'(-2): r.t = sval_t'(-1);
      sval_t'(1): begin
        r.t = lo_neg ? sval_t'(0) : sval_t'(1);
        r.w = lo_neg ? sval_t'(1) : sval_t'(-1);
      end
      sval_t'(-1): begin
        r.t = lo_neg ? sval_t'(-1) : sval_t'(0);
        r.w = lo_neg ? sval_t'(1) : sval_t'(-1);
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sd_lfsr_addr.sv
module sd_lfsr_addr #(
  parameter int unsigned LFSR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              advance_i,
  output logic [LFSR_W-1:0] addr_o,
  output logic [LFSR_W-1:0] state_o
);
  import sdadd_pkg::*;

  localparam logic [7:0]        TapsAll = tap_mask(LFSR_W);
  localparam logic [LFSR_W-1:0] Taps    = TapsAll[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] Seed    = LFSR_W'(1);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] next_state;

  assign addr_o     = restart_i ? Seed : state_q;
  assign next_state = {addr_o[LFSR_W-2:0], ^(addr_o & Taps)};
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= Seed;
    else if (advance_i) state_q <= next_state;
  end

endmodule

// File: rtl/sd_coef_mem.sv
module sd_coef_mem #(
  parameter int unsigned LFSR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LFSR_W-1:0] waddr_i,
  input  logic              wbit_i,
  input  logic [LFSR_W-1:0] raddr_i,
  output logic              rbit_o
);
  localparam int unsigned Depth = 2 ** LFSR_W;

  logic [Depth-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wbit_i;
  end

  assign rbit_o = mem_q[raddr_i];

endmodule

// File: rtl/sd_online_add.sv
module sd_online_add (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic       in_first_i,
  input  logic [1:0] sd_i,
  input  logic       coef_bit_i,
  output logic [1:0] sd_o,
  output logic       valid_o
);
  import sdadd_pkg::*;

  sval_t x_val, y_val, p_now;
  sval_t p1_q, p2_q, p3_q;   // position sums, newest first
  logic  v1_q, v2_q, v3_q;
  logic  f1_q, f2_q;
  xfer_t up_split, mid_split;
  sval_t s_now;
  logic  s_valid;

  assign x_val = dig_val(sd_i);
  // two's complement MSB enters with negative weight
  assign y_val = !coef_bit_i ? sval_t'(0) : (in_first_i ? sval_t'(-1) : sval_t'(1));
  assign p_now = in_valid_i ? sval_t'(x_val + y_val) : sval_t'(0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0; p2_q <= '0; p3_q <= '0;
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0;
      f1_q <= 1'b0; f2_q <= 1'b0;
    end else begin
      p1_q <= p_now;  p2_q <= p1_q; p3_q <= p2_q;
      v1_q <= in_valid_i; v2_q <= v1_q; v3_q <= v2_q;
      f1_q <= in_valid_i & in_first_i; f2_q <= f1_q;
    end
  end

  // digit at p3 position: interim from (p3,p2) plus transfer from (p2,p1)
  assign up_split  = split(p3_q, p2_q);
  assign mid_split = split(p2_q, p1_q);
  assign s_valid   = v3_q | (v2_q & f2_q);
  assign s_now     = sval_t'(up_split.w + mid_split.t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o    <= 2'b00;
      valid_o <= 1'b0;
    end else begin
      sd_o    <= s_valid ? dig_enc(s_now) : 2'b00;
      valid_o <= s_valid;
    end
  end

endmodule

// File: rtl/sd_coef_adder.sv
module sd_coef_adder #(
  parameter int unsigned LFSR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        sd_i,
  input  logic              coef_we_i,
  input  logic [LFSR_W-1:0] coef_addr_i,
  input  logic              coef_bit_i,
  output logic [1:0]        sd_o,
  output logic              sd_valid_o
);
  localparam int unsigned WordLen = 2 ** LFSR_W - 1;
  localparam int unsigned IdxW    = $clog2(WordLen + 1);

  logic            run_q;
  logic [IdxW-1:0] idx_q;
  logic [IdxW-1:0] idx_now;
  logic            in_valid, in_last;
  logic [LFSR_W-1:0] rd_addr, lfsr_q;
  logic            coef_bit;

  assign in_valid = start_i | run_q;
  assign idx_now  = start_i ? '0 : idx_q;
  assign in_last  = idx_now == IdxW'(WordLen - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (in_valid && !in_last) begin
      run_q <= 1'b1;
      idx_q <= idx_now + IdxW'(1);
    end else begin
      run_q <= 1'b0;
      idx_q <= '0;
    end
  end

  sd_lfsr_addr #(.LFSR_W(LFSR_W)) i_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start_i),
    .advance_i (in_valid),
    .addr_o    (rd_addr),
    .state_o   (lfsr_q)
  );

  sd_coef_mem #(.LFSR_W(LFSR_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (coef_we_i),
    .waddr_i (coef_addr_i),
    .wbit_i  (coef_bit_i),
    .raddr_i (rd_addr),
    .rbit_o  (coef_bit)
  );

  sd_online_add i_add (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .in_first_i (start_i),
    .sd_i       (sd_i),
    .coef_bit_i (coef_bit),
    .sd_o       (sd_o),
    .valid_o    (sd_valid_o)
  );

endmodule

// File: rtl/sd_coef_adder_chk.sv
module sd_coef_adder_chk #(
  parameter int unsigned LFSR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        sd_o,
  input logic              sd_valid_o,
  input logic [LFSR_W-1:0] lfsr_state
);

  assert_legal_digit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_o != 2'b11);

  assert_latency_three_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##3 sd_valid_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_valid_o |-> sd_o == 2'b00);

  assert_valid_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_valid_o |-> ($past(start_i, 3) || $past(sd_valid_o)));

  assert_lfsr_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0);

endmodule

bind sd_coef_adder sd_coef_adder_chk #(.LFSR_W(LFSR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .sd_o       (sd_o),
  .sd_valid_o (sd_valid_o),
  .lfsr_state (lfsr_q)
);

// File: tb/test_sd_coef_adder.sv
module test_sd_coef_adder;
  localparam int W = 3;
  localparam int N = 7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   sd_i = 2'b00;
  logic         coef_we_i = 1'b0;
  logic [W-1:0] coef_addr_i = '0;
  logic         coef_bit_i = 1'b0;
  logic [1:0]   sd_o;
  logic         sd_valid_o;

  sd_coef_adder #(.LFSR_W(W)) i_sd_coef_adder (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int exp_val [0:255];
  int exp_cyc [0:255];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int dig [0:N-1];
  int coef_val = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int dval(logic [1:0] d);
    return d == 2'b10 ? 1 : (d == 2'b01 ? -1 : 0);
  endfunction

  function automatic logic [1:0] denc(int v);
    return v > 0 ? 2'b10 : (v < 0 ? 2'b01 : 2'b00);
  endfunction

  // R3: seed 1, shift left, new bit0 = bit2 ^ bit1
  function automatic logic [W-1:0] lfsr_at(int k);
    logic [W-1:0] s;
    s = 3'd1;
    for (int i = 0; i < k; i++) s = {s[1:0], s[2] ^ s[1]};
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // output monitor
  int acc = 0;
  int ndig = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (sd_valid_o) begin
        check(sd_o != 2'b11, "R1 digit code", int'(sd_o), 0);
        if (ndig == 0) check(cyc == exp_cyc[rd_ptr], "R6 first digit cycle", cyc, exp_cyc[rd_ptr]);
        acc = acc * 2 + dval(sd_o);
        ndig++;
        if (ndig == N + 1) begin
          check(rd_ptr != wr_ptr && acc == exp_val[rd_ptr], "R5 R4 R3 sum value", acc, exp_val[rd_ptr]);
          rd_ptr = (rd_ptr + 1) % 256;
          ndig = 0;
          acc = 0;
        end
      end else begin
        check(sd_o == 2'b00, "R7 idle output", int'(sd_o), 0);
        check(ndig == 0, "R5 digits contiguous", ndig, 0);
      end
    end
  end

  task automatic load_coef(int c);
    logic [N-1:0] bits;
    coef_val = c;
    bits = N'(c);
    for (int k = 0; k < N; k++) begin
      @(negedge clk_i);
      coef_we_i = 1'b1;
      coef_addr_i = lfsr_at(k);
      coef_bit_i = bits[N-1-k];
    end
    @(negedge clk_i);
    coef_addr_i = '0;
    coef_bit_i = 1'b0;
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  // R2: word of N digits, then gap idle cycles carrying junk input
  task automatic run_word(int gap);
    int x;
    x = 0;
    for (int k = 0; k < N; k++) x = x * 2 + dig[k];
    for (int k = 0; k < N; k++) begin
      @(negedge clk_i);
      if (k == 0) begin
        exp_val[wr_ptr] = x + coef_val;
        exp_cyc[wr_ptr] = cyc + 3;
        wr_ptr = (wr_ptr + 1) % 256;
      end
      start_i = (k == 0);
      sd_i = denc(dig[k]);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      sd_i = ($urandom % 2) ? 2'b10 : 2'b01;  // ignored outside a word
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk_i);
    check(sd_valid_o == 1'b0, "R8 reset valid", int'(sd_valid_o), 0);
    check(sd_o == 2'b00, "R8 reset digit", int'(sd_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(sd_valid_o == 1'b0 && sd_o == 2'b00, "R8 after reset", int'({sd_valid_o, sd_o}), 0);

    for (int c = -(2 ** (N - 1)); c < 2 ** (N - 1); c++) begin
      load_coef(c);
      for (int k = 0; k < N; k++) dig[k] = 1;
      run_word(1);
      for (int k = 0; k < N; k++) dig[k] = -1;
      run_word(1 + $urandom % 3);
      for (int k = 0; k < N; k++) dig[k] = 0;
      run_word(1);
      for (int k = 0; k < N; k++) dig[k] = (k % 2 == 0) ? 1 : -1;
      run_word(2);
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < N; k++) dig[k] = int'($urandom % 3) - 1;
        run_word(1 + $urandom % 4);
      end
      repeat (6) @(negedge clk_i);
    end
    repeat (8) @(negedge clk_i);
    check(rd_ptr == wr_ptr, "R5 all words returned", rd_ptr, wr_ptr);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule